// File: doc/BRIEF.md
# Nine-Valued Fault-Pair Gate Evaluator

This block takes a small gate netlist held in its own table and simulates it in two machines at once: a machine without the fault and a machine with one stuck-at fault. Every net carries a pair of values, the fault-free value first and the faulty value second. Each value of the pair is 0, 1 or unknown, so a net can take one of nine symbols: 0/0, 1/1, X/X, the discrepancies 1/0 (D) and 0/1 (D-bar), and the partly known 0/X, 1/X, X/0 and X/1.

Software or a search engine loads the gate table one entry at a time. It then applies composite primary-input values, a fault net and a stuck polarity, and pulses start. The block evaluates one gate per clock in table order and injects the fault at the chosen net. When it finishes, it reports four results. The first is the composite value of each primary output. The second is whether any output shows a discrepancy, which means a test has been found. The third is a per-gate mask of the D-frontier. The fourth is a flag for the dead-end case, in which no discrepancy reached an output and the frontier is empty. The block does no search, backtracking or justification; it answers one trial assignment per start.

Top module: `fpe_eval`

## Requirements
- R1: A composite value is 4 bits, {good[1:0], faulty[1:0]}, with field codes 00 = 0, 01 = 1, and 10 or 11 = X. Primary input i sits in pi_val[4i+3:4i] and primary output p sits in po_val[4p+3:4p].
- R2: AND (type 0) and NAND (type 2) work on each machine separately. A 0 on either input gives AND 0, 1 on both inputs gives AND 1, and anything else gives X. NAND is the complement of AND, and the complement of X is X.
- R3: OR (type 1) and NOR (type 3) work on each machine separately. A 1 on either input gives OR 1, 0 on both inputs gives OR 0, and anything else gives X. NOR is the complement of OR.
- R4: NOT (type 4) and BUF (type 6) use source a only. XOR (type 5) and XNOR (type 7) give X when either input is X, and otherwise give the exclusive-or or its complement. All of these work on each machine separately.
- R5: The faulty field of the net numbered fault_net is forced to fault_sa (0 gives code 00, 1 gives code 01), and its good field is unchanged. Nets 0..N_PI-1 are the primary inputs and net N_PI+g is the output of gate g. A fault_net of N_PI+N_GATES or above injects nothing.
- R6: On a start pulse, the block latches the inputs and the fault and sets every gate net to X/X. Gate g is then evaluated at the (g+1)-th clock edge after start. busy is high during evaluation, and done rises exactly N_GATES cycles after the start edge and stays high until the next start. A source index that names a gate net not yet evaluated in this pass, or a net number of N_PI+N_GATES or above, reads X/X.
- R7: Primary output p is the output of gate N_GATES-N_PO+p.
- R8: test_found is high when done is high and some primary output has both fields known and different.
- R9: dfront[g] is set when some input of gate g carries D or D-bar and the output of gate g has at least one X field. The inputs counted are source a, plus source b for two-input types. The output is taken after any injection.
- R10: no_test is high when done is high, test_found is low and dfront is all zero.
- R11: After reset, busy, done, test_found, no_test and dfront are 0, and every output reads X/X (code 1010).
- R12: A table write (cfg_we) replaces the type and both sources of entry cfg_idx. The new entry is used from the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Gate table write strobe |
| cfg_idx | input | 5 | Gate table entry to write |
| cfg_type | input | 3 | Gate type code |
| cfg_src_a | input | 6 | Net number of source a |
| cfg_src_b | input | 6 | Net number of source b |
| start | input | 1 | Begin one evaluation pass |
| pi_val | input | 32 | Composite primary-input values |
| fault_net | input | 6 | Net carrying the stuck-at fault |
| fault_sa | input | 1 | Stuck polarity, 1 = stuck-at-1 |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | Pass complete, results valid |
| po_val | output | 16 | Composite primary-output values |
| test_found | output | 1 | Discrepancy at some output |
| no_test | output | 1 | No discrepancy and empty D-frontier |
| dfront | output | 32 | D-frontier mask, one bit per gate |

## Verification
Directed netlists isolate each gate family under partly known inputs. Examples are a NAND with X and 0, a NOR with 1/X and X, and an XOR with 1 and X/0. Each result is compared with literal symbols, which separates per-machine evaluation from a combined five-valued shortcut. Fault cases put a stuck-at-0 on an activated input and a stuck-at-1 on a gate net, and check that D and D-bar reach the outputs. A blocked AND separates a live frontier from a dead end by setting its activating input to 1 or 0. Random tables, which include forward and out-of-range sources and the spare 11 field code, are checked against two independent three-valued simulations. These cover ordering and X handling that the directed cases do not reach.

// File: rtl/fpe_pkg.sv
package fpe_pkg;

   typedef logic [1:0] tv_t;

   localparam tv_t TV0 = 2'b00;
   localparam tv_t TV1 = 2'b01;
   localparam tv_t TVX = 2'b10;

   typedef struct packed {
      tv_t good;
      tv_t bad;
   } pair_t;

   localparam pair_t PAIR_X = '{good: TVX, bad: TVX};

   typedef enum logic [2:0] {
      G_AND  = 3'd0,
      G_OR   = 3'd1,
      G_NAND = 3'd2,
      G_NOR  = 3'd3,
      G_NOT  = 3'd4,
      G_XOR  = 3'd5,
      G_BUF  = 3'd6,
      G_XNOR = 3'd7
   } gtype_e;

   function automatic logic tv_known(tv_t v);
      return (v[1] == 1'b0);
   endfunction

   function automatic tv_t tv_norm(tv_t v);
      return tv_known(v) ? v : TVX;
   endfunction

   function automatic tv_t tv_not(tv_t v);
      tv_t n;
      n = tv_norm(v);
      if (n == TV0) return TV1;
      if (n == TV1) return TV0;
      return TVX;
   endfunction

   function automatic tv_t tv_and(tv_t a, tv_t b);
      tv_t na, nb;
      na = tv_norm(a);
      nb = tv_norm(b);
      if (na == TV0 || nb == TV0) return TV0;
      if (na == TV1 && nb == TV1) return TV1;
      return TVX;
   endfunction

   function automatic tv_t tv_or(tv_t a, tv_t b);
      tv_t na, nb;
      na = tv_norm(a);
      nb = tv_norm(b);
      if (na == TV1 || nb == TV1) return TV1;
      if (na == TV0 && nb == TV0) return TV0;
      return TVX;
   endfunction

   function automatic tv_t tv_xor(tv_t a, tv_t b);
      if (!tv_known(a) || !tv_known(b)) return TVX;
      return (a == b) ? TV0 : TV1;
   endfunction

   function automatic tv_t tv_eval(gtype_e t, tv_t a, tv_t b);
      case (t)
         G_AND:   return tv_and(a, b);
         G_OR:    return tv_or(a, b);
         G_NAND:  return tv_not(tv_and(a, b));
         G_NOR:   return tv_not(tv_or(a, b));
         G_NOT:   return tv_not(a);
         G_XOR:   return tv_xor(a, b);
         G_BUF:   return tv_norm(a);
         default: return tv_not(tv_xor(a, b));
      endcase
   endfunction

   function automatic logic pair_disc(pair_t p);
      return tv_known(p.good) && tv_known(p.bad) && (p.good != p.bad);
   endfunction

   function automatic logic pair_has_x(pair_t p);
      return !tv_known(p.good) || !tv_known(p.bad);
   endfunction

endpackage

// File: rtl/fpe_table.sv
module fpe_table
   import fpe_pkg::*;
#(
   parameter int N_GATES = 32,
   parameter int NET_W   = 6,
   localparam int GI_W   = $clog2(N_GATES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [GI_W-1:0]   wr_idx,
   input  logic [2:0]        wr_type,
   input  logic [NET_W-1:0]  wr_a,
   input  logic [NET_W-1:0]  wr_b,
   input  logic [GI_W-1:0]   rd_idx,
   output gtype_e            rd_type,
   output logic [NET_W-1:0]  rd_a,
   output logic [NET_W-1:0]  rd_b
);

   gtype_e             typ_q [N_GATES];
   logic [NET_W-1:0]   a_q   [N_GATES];
   logic [NET_W-1:0]   b_q   [N_GATES];

   for (genvar g = 0; g < N_GATES; g++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            typ_q[g] <= G_BUF;
            a_q[g]   <= '0;
            b_q[g]   <= '0;
         end else if (wr_en && (wr_idx == GI_W'(g))) begin
            typ_q[g] <= gtype_e'(wr_type);
            a_q[g]   <= wr_a;
            b_q[g]   <= wr_b;
         end
      end
   end

   assign rd_type = typ_q[rd_idx];
   assign rd_a    = a_q[rd_idx];
   assign rd_b    = b_q[rd_idx];

endmodule

// File: rtl/fpe_gate_alu.sv
module fpe_gate_alu
   import fpe_pkg::*;
(
   input  gtype_e typ,
   input  pair_t  va,
   input  pair_t  vb,
   input  logic   inj_en,
   input  logic   inj_val,
   output pair_t  y,
   output logic   frontier
);

   logic [1:0][1:0] lane_a;
   logic [1:0][1:0] lane_b;
   logic [1:0][1:0] lane_y;
   logic            two_in;

   assign lane_a = va;
   assign lane_b = vb;

   for (genvar l = 0; l < 2; l++) begin : g_lane
      assign lane_y[l] = tv_eval(typ, lane_a[l], lane_b[l]);
   end

   assign y.good = lane_y[1];
   assign y.bad  = inj_en ? (inj_val ? TV1 : TV0) : lane_y[0];

   assign two_in   = (typ != G_NOT) && (typ != G_BUF);
   assign frontier = (pair_disc(va) || (two_in && pair_disc(vb))) && pair_has_x(y);

endmodule

// File: rtl/fpe_detect.sv
module fpe_detect
   import fpe_pkg::*;
#(
   parameter int N_PO = 4
) (
   input  logic [4*N_PO-1:0] po_flat,
   output logic              any_disc
);

   logic [N_PO-1:0] disc;

   for (genvar p = 0; p < N_PO; p++) begin : g_po
      assign disc[p] = pair_disc(pair_t'(po_flat[4*p +: 4]));
   end

   assign any_disc = |disc;

endmodule

// File: rtl/fpe_eval.sv
module fpe_eval
   import fpe_pkg::*;
#(
   parameter int N_PI    = 8,
   parameter int N_GATES = 32,
   parameter int N_PO    = 4,
   parameter int NET_W   = 6,
   localparam int GI_W   = $clog2(N_GATES)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [GI_W-1:0]     cfg_idx,
   input  logic [2:0]          cfg_type,
   input  logic [NET_W-1:0]    cfg_src_a,
   input  logic [NET_W-1:0]    cfg_src_b,
   input  logic                start,
   input  logic [4*N_PI-1:0]   pi_val,
   input  logic [NET_W-1:0]    fault_net,
   input  logic                fault_sa,
   output logic                busy,
   output logic                done,
   output logic [4*N_PO-1:0]   po_val,
   output logic                test_found,
   output logic                no_test,
   output logic [N_GATES-1:0]  dfront
);

   localparam int N_NETS = N_PI + N_GATES;
   localparam int LAST   = N_GATES - 1;
   localparam int PO_LO  = N_GATES - N_PO;

   if (N_PI < 1) begin : g_bad_pi
      $error("fpe_eval: N_PI must be at least 1");
   end
   if (N_GATES < 2) begin : g_bad_gates
      $error("fpe_eval: N_GATES must be at least 2");
   end
   if (N_PO < 1 || N_PO > N_GATES) begin : g_bad_po
      $error("fpe_eval: N_PO must lie in 1..N_GATES");
   end
   if (N_NETS > (1 << NET_W)) begin : g_bad_netw
      $error("fpe_eval: NET_W too narrow for all nets");
   end

   pair_t              nets_q [N_NETS];
   pair_t              pi_inj [N_PI];
   logic [GI_W-1:0]    cnt_q;
   logic               busy_q;
   logic               done_q;
   logic [N_GATES-1:0] dfront_q;
   logic [NET_W-1:0]   fnet_q;
   logic               fsa_q;

   gtype_e             cur_type;
   logic [NET_W-1:0]   cur_a;
   logic [NET_W-1:0]   cur_b;
   pair_t              va;
   pair_t              vb;
   pair_t              y;
   logic               fr;
   logic [NET_W-1:0]   wr_net;
   logic               inj_en;
   logic               any_disc;

   fpe_table #(
      .N_GATES (N_GATES),
      .NET_W   (NET_W)
   ) u_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we),
      .wr_idx  (cfg_idx),
      .wr_type (cfg_type),
      .wr_a    (cfg_src_a),
      .wr_b    (cfg_src_b),
      .rd_idx  (cnt_q),
      .rd_type (cur_type),
      .rd_a    (cur_a),
      .rd_b    (cur_b)
   );

   // source fetch: nets above the last one read unknown
   always_comb begin
      va = PAIR_X;
      vb = PAIR_X;
      if (int'(cur_a) < N_NETS) va = nets_q[cur_a];
      if (int'(cur_b) < N_NETS) vb = nets_q[cur_b];
   end

   assign wr_net = NET_W'(N_PI) + NET_W'(cnt_q);
   assign inj_en = (fnet_q == wr_net);

   fpe_gate_alu u_alu (
      .typ      (cur_type),
      .va       (va),
      .vb       (vb),
      .inj_en   (inj_en),
      .inj_val  (fsa_q),
      .y        (y),
      .frontier (fr)
   );

   // primary inputs with the fault applied at load
   for (genvar i = 0; i < N_PI; i++) begin : g_pi
      always_comb begin
         pi_inj[i] = pair_t'(pi_val[4*i +: 4]);
         if (fault_net == NET_W'(i)) pi_inj[i].bad = fault_sa ? TV1 : TV0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int n = 0; n < N_NETS; n++) nets_q[n] <= PAIR_X;
         cnt_q    <= '0;
         busy_q   <= 1'b0;
         done_q   <= 1'b0;
         dfront_q <= '0;
         fnet_q   <= '0;
         fsa_q    <= 1'b0;
      end else if (start) begin
         for (int n = 0; n < N_PI; n++) nets_q[n] <= pi_inj[n];
         for (int n = N_PI; n < N_NETS; n++) nets_q[n] <= PAIR_X;
         cnt_q    <= '0;
         busy_q   <= 1'b1;
         done_q   <= 1'b0;
         dfront_q <= '0;
         fnet_q   <= fault_net;
         fsa_q    <= fault_sa;
      end else if (busy_q) begin
         nets_q[wr_net]  <= y;
         dfront_q[cnt_q] <= fr;
         if (cnt_q == GI_W'(LAST)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   for (genvar p = 0; p < N_PO; p++) begin : g_out
      assign po_val[4*p +: 4] = nets_q[N_PI + PO_LO + p];
   end

   fpe_detect #(
      .N_PO (N_PO)
   ) u_detect (
      .po_flat  (po_val),
      .any_disc (any_disc)
   );

   assign busy       = busy_q;
   assign done       = done_q;
   assign dfront     = dfront_q;
   assign test_found = done_q & any_disc;
   assign no_test    = done_q & ~any_disc & ~(|dfront_q);

endmodule

// File: rtl/fpe_chk.sv
module fpe_chk #(
   parameter int N_GATES = 32,
   parameter int GI_W    = 5
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start,
   input logic               busy,
   input logic               done,
   input logic               test_found,
   input logic               no_test,
   input logic [N_GATES-1:0] dfront,
   input logic [GI_W-1:0]    cnt
);

   p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));

   p_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (busy && !done && cnt == '0));

   p_finish_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !start && cnt == GI_W'(N_GATES - 1)) |=> done);

   p_found_r8: assert property (@(posedge clk) disable iff (!rst_n)
      test_found |-> (done && !no_test));

   p_notest_r10: assert property (@(posedge clk) disable iff (!rst_n)
      no_test |-> (done && dfront == '0));

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> $stable(dfront));

endmodule

bind fpe_eval fpe_chk #(
   .N_GATES (N_GATES),
   .GI_W    (GI_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .busy       (busy),
   .done       (done),
   .test_found (test_found),
   .no_test    (no_test),
   .dfront     (dfront),
   .cnt        (cnt_q)
);

// File: tb/fpe_eval_tb.sv
`timescale 1ns/1ps
module fpe_eval_tb_top;

   localparam int NPI = 8;
   localparam int NG  = 32;
   localparam int NPO = 4;
   localparam int NW  = 6;
   localparam int NN  = NPI + NG;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cfg_we = 1'b0;
   logic [4:0]      cfg_idx = '0;
   logic [2:0]      cfg_type = '0;
   logic [NW-1:0]   cfg_src_a = '0;
   logic [NW-1:0]   cfg_src_b = '0;
   logic            start = 1'b0;
   logic [4*NPI-1:0] pi_val = '0;
   logic [NW-1:0]   fault_net = '0;
   logic            fault_sa = 1'b0;
   logic            busy, done, test_found, no_test;
   logic [4*NPO-1:0] po_val;
   logic [NG-1:0]   dfront;

   int total = 0;
   int bad = 0;
   int t_typ [NG];
   int t_a   [NG];
   int t_b   [NG];

   always #2 clk = ~clk;

   fpe_eval dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_type(cfg_type), .cfg_src_a(cfg_src_a), .cfg_src_b(cfg_src_b),
      .start(start), .pi_val(pi_val), .fault_net(fault_net),
      .fault_sa(fault_sa), .busy(busy), .done(done), .po_val(po_val),
      .test_found(test_found), .no_test(no_test), .dfront(dfront)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // three-valued reference: 0, 1, 2 = unknown
   function automatic int m_n(int v); return (v >= 2) ? 2 : v; endfunction
   function automatic int m_not(int v); return (m_n(v) == 2) ? 2 : 1 - v; endfunction
   function automatic int m_and(int a, int b);
      if (m_n(a) == 0 || m_n(b) == 0) return 0;
      if (m_n(a) == 1 && m_n(b) == 1) return 1;
      return 2;
   endfunction
   function automatic int m_or(int a, int b);
      if (m_n(a) == 1 || m_n(b) == 1) return 1;
      if (m_n(a) == 0 && m_n(b) == 0) return 0;
      return 2;
   endfunction
   function automatic int m_xor(int a, int b);
      if (m_n(a) == 2 || m_n(b) == 2) return 2;
      return (a == b) ? 0 : 1;
   endfunction
   function automatic int m_eval(int t, int a, int b);
      case (t)
         0: return m_and(a, b);
         1: return m_or(a, b);
         2: return m_not(m_and(a, b));
         3: return m_not(m_or(a, b));
         4: return m_not(a);
         5: return m_xor(a, b);
         6: return m_n(a);
         default: return m_not(m_xor(a, b));
      endcase
   endfunction
   function automatic bit m_disc(int g, int f);
      return (g < 2) && (f < 2) && (g != f);
   endfunction

   task automatic model(input logic [4*NPI-1:0] piv, input int fn, input int sa,
                        output logic [4*NPO-1:0] po, output logic tf, output logic nt,
                        output logic [NG-1:0] df);
      int gm [64];
      int fm [64];
      for (int i = 0; i < 64; i++) begin gm[i] = 2; fm[i] = 2; end
      for (int i = 0; i < NPI; i++) begin
         gm[i] = int'(piv[4*i+2 +: 2]);
         fm[i] = (fn == i) ? sa : int'(piv[4*i +: 2]);
      end
      df = '0;
      for (int k = 0; k < NG; k++) begin
         int ag, af, bg, bf, yg, yf;
         bit two;
         ag = gm[t_a[k]]; af = fm[t_a[k]];
         bg = gm[t_b[k]]; bf = fm[t_b[k]];
         yg = m_eval(t_typ[k], ag, bg);
         yf = m_eval(t_typ[k], af, bf);
         if (fn == NPI + k) yf = sa;
         two = (t_typ[k] != 4) && (t_typ[k] != 6);
         df[k] = (m_disc(ag, af) || (two && m_disc(bg, bf))) && (yg == 2 || yf == 2);
         gm[NPI + k] = yg;
         fm[NPI + k] = yf;
      end
      tf = 1'b0;
      for (int p = 0; p < NPO; p++) begin
         int gi;
         gi = NPI + NG - NPO + p;
         po[4*p +: 4] = {2'(gm[gi]), 2'(fm[gi])};
         if (m_disc(gm[gi], fm[gi])) tf = 1'b1;
      end
      nt = !tf && (df == '0);
   endtask

   task automatic wr_gate(input int g, input int ty, input int a, input int b);
      t_typ[g] = ty; t_a[g] = a; t_b[g] = b;
      cfg_idx = 5'(g); cfg_type = 3'(ty); cfg_src_a = NW'(a); cfg_src_b = NW'(b);
      cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic run(input string tag, input logic [4*NPI-1:0] piv, input int fn, input int sa);
      logic [4*NPO-1:0] e_po;
      logic e_tf, e_nt;
      logic [NG-1:0] e_df;
      int cycles;
      pi_val = piv; fault_net = NW'(fn); fault_sa = sa[0];
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cycles = 1;
      while (!done && cycles < 300) begin
         @(negedge clk);
         cycles++;
      end
      chk({tag, " R6 done latency"}, 64'(cycles), 64'(NG + 1));
      model(piv, fn, sa, e_po, e_tf, e_nt, e_df);
      chk({tag, " R7 po_val"}, 64'(po_val), 64'(e_po));
      chk({tag, " R8 test_found"}, 64'(test_found), 64'(e_tf));
      chk({tag, " R9 dfront"}, 64'(dfront), 64'(e_df));
      chk({tag, " R10 no_test"}, 64'(no_test), 64'(e_nt));
   endtask

   initial begin
      #(4 * 150000);
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      for (int g = 0; g < NG; g++) begin t_typ[g] = 6; t_a[g] = 0; t_b[g] = 0; end
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 busy", 64'(busy), 64'd0);
      chk("R11 done", 64'(done), 64'd0);
      chk("R11 po_val", 64'(po_val), 64'hAAAA);
      chk("R11 flags", 64'({test_found, no_test}), 64'd0);
      chk("R11 dfront", 64'(dfront), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R5: AND of two 1s, stuck-at-0 on input 0, BUF chain -> D everywhere
      wr_gate(0, 0, 0, 1);
      for (int g = 1; g < NG; g++) wr_gate(g, 6, NPI + g - 1, 0);
      run("R1 R5 sa0", 32'h0000_0055, 0, 0);
      chk("R1 R5 D symbol", 64'(po_val), 64'h4444);
      chk("R8 D found", 64'(test_found), 64'd1);

      // R5: stuck-at-1 on gate net 0 driven to 0 -> D-bar
      wr_gate(0, 6, 0, 0);
      run("R5 gate sa1", 32'h0000_0000, NPI, 1);
      chk("R5 Dbar symbol", 64'(po_val), 64'h1111);

      // R2: NAND(X, 0) = 1/1
      for (int g = 0; g < NG; g++) wr_gate(g, 2, 0, 1);
      run("R2 nand", 32'h0000_000A, 63, 0);
      chk("R2 nand literal", 64'(po_val), 64'h5555);

      // R12: rewrite last entry as BUF of input 1 (0/0)
      wr_gate(NG - 1, 6, 1, 0);
      run("R12 rewrite", 32'h0000_000A, 63, 0);
      chk("R12 rewrite literal", 64'(po_val), 64'h0555);

      // R3: NOR(1/X, X) = 0/X
      for (int g = 0; g < NG; g++) wr_gate(g, 3, 0, 1);
      run("R3 nor", 32'h0000_00A6, 63, 0);
      chk("R3 nor literal", 64'(po_val), 64'h2222);

      // R4: XOR(1, X/0) = X/1
      for (int g = 0; g < NG; g++) wr_gate(g, 5, 0, 1);
      run("R4 xor", 32'h0000_0085, 63, 0);
      chk("R4 xor literal", 64'(po_val), 64'h9999);

      // R9: AND(D, X) blocked, rest BUF of 0/0 input
      wr_gate(0, 0, 0, 1);
      for (int g = 1; g < NG; g++) wr_gate(g, 6, 2, 0);
      run("R9 frontier", 32'h0000_00A5, 0, 0);
      chk("R9 frontier literal", 64'(dfront), 64'h1);
      chk("R10 frontier alive", 64'(no_test), 64'd0);

      // R10: fault not activated -> dead end
      run("R10 dead", 32'h0000_00A0, 0, 0);
      chk("R10 dead literal", 64'(no_test), 64'd1);

      // random tables and vectors (R2 R3 R4 R5 R6 R7)
      for (int r = 0; r < 160; r++) begin
         logic [4*NPI-1:0] piv;
         int fn;
         for (int g = 0; g < NG; g++) begin
            int a, b;
            if ($urandom % 8 == 0) a = $urandom % 64; else a = $urandom % (NPI + g);
            if ($urandom % 8 == 0) b = $urandom % 64; else b = $urandom % (NPI + g);
            wr_gate(g, $urandom % 8, a, b);
         end
         for (int i = 0; i < NPI; i++) begin
            piv[4*i+2 +: 2] = ($urandom % 4 == 0) ? 2'(2 + $urandom % 2) : 2'($urandom % 2);
            piv[4*i +: 2]   = ($urandom % 4 == 0) ? 2'(2 + $urandom % 2) : 2'($urandom % 2);
         end
         fn = ($urandom % 10 == 0) ? 63 : $urandom % NN;
         run("rand R2 R3 R4 R5", piv, fn, $urandom % 2);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule